// File: doc/BRIEF.md
# Indirect configuration register file

This block holds the configuration state of a two-channel disk interface bridge and gives a host access to it through four byte locations. A pointer byte names a channel and a register index, and a word-wide data port then reads or writes the selected register. Each channel owns seven registers: two 16-bit I/O base addresses, a general configuration byte, a 10-bit read-ahead count split over two write-only locations, and two timing bytes. When its advance bit is set, the pointer steps to the next index after every data-port access, so a host can stream through one channel's registers.

Two further fixed locations hold the interrupt mask and the chip test controls. Each also returns live interrupt status from the channel logic. Each channel drives an interrupt line equal to its device interrupt status gated by its mask bit. The host side is a simple strobe interface: one address, a write or read strobe, two byte enables and a 16-bit data bus. Read data is combinational. Writes and pointer steps take effect at the clock edge.

Top module: `cfgport_regbank`

## Requirements
- R1: After reset the pointer (offset 1) reads 0x50 and the mask location reads zero mask bits. For the primary and secondary channels respectively, index 0 reads 0x01F0 and 0x0170, index 4 reads 0x03F6 and 0x0376, index 1 reads 0x01, index 5 reads 0x00F5 and index 6 reads 0x00DE.
- R2: Pointer bit 3 picks the channel (0 primary, 1 secondary) and bits 2..0 pick the index used by the data port at offset 0. Pointer bit 5 is write-only: it drives `burst_off` and always reads back as 0. The other pointer bits read back as written.
- R3: With pointer bit 7 set, every data-port read or write advances pointer bits 2..0 by one at the clock edge. Index 6, and also index 7, advance to 0.
- R4: With pointer bit 7 clear, data-port accesses leave the pointer unchanged.
- R5: At indices 0 and 4, byte enable bit 0 writes data bits 7..0 and byte enable bit 1 writes bits 15..8. A low-byte-only write leaves the high byte unchanged. All byte-wide registers are written from data bits 7..0 only when byte enable bit 0 is set, and they read with bits 15..8 at zero.
- R6: Indices 2 and 3 always read as zero. Bit 2 of index 1 is write-only and reads as zero. The read-ahead count output equals {index 3 bits 1..0, index 2 bits 7..0}. Index 3 bit 7 drives `ra_enable` and bit 4 drives `mode4_tim`.
- R7: A write to index 3 with data bit 6 set raises that channel's `fifo_clr` for exactly the following cycle. The bit is not stored.
- R8: Index 7 reads as zero and writes to it change no register.
- R9: A write to offset 2 sets `legacy_mode` from data bit 1 and `test_mode` from data bit 0. A read of offset 2 returns the channel 0 bus-master status in bit 1 and the channel 0 device status in bit 0, with all other bits zero.
- R10: Offset 3 bits 1..0 are the channel 1 and channel 0 mask bits and are writable. Reads return the channel 1 bus-master status in bit 3, the channel 1 device status in bit 2 and the legacy strap in bit 4, with bits 15..5 zero. Writes have no effect on bits 4..2.
- R11: `irq_out[c]` equals device status of channel c AND NOT mask bit c. It follows a mask write from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Location: 0 data port, 1 pointer, 2 chip test/status, 3 mask |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (advances the pointer on data-port reads) |
| host_be | input | 2 | Byte enables for low and high data byte |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the addressed location |
| irq_dev_stat | input | 2 | Device interrupt status per channel |
| irq_bm_stat | input | 2 | Bus-master interrupt status per channel |
| legacy_strap | input | 1 | Legacy-header strap |
| irq_out | output | 2 | Masked interrupt per channel |
| legacy_mode | output | 1 | Legacy compatible mode select |
| test_mode | output | 1 | Test mode select |
| burst_off | output | 1 | Master burst disable from pointer bit 5 |
| fifo_clr | output | 2 | One-cycle FIFO clear pulse per channel |
| ra_enable | output | 2 | Read-ahead enable per channel |
| mode4_tim | output | 2 | Fast timing control per channel |
| ra_count_p | output | 10 | Primary read-ahead count |
| ra_count_s | output | 10 | Secondary read-ahead count |

## Verification
A corrupted pointer shows up at the next data-port read as a value from the wrong channel or index. A pointer read shows it directly. Because read data is combinational, a bad register bit is visible in the same cycle the host addresses it. Write-only state cannot be read back, so it is checked at the read-ahead, enable and pulse outputs one cycle after the write. A bad mask bit shows on `irq_out` in the cycle after the mask write, for whichever status pattern is applied.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int NCH    = 2;
    localparam int NREG   = 7;
    localparam int IDX_W  = 3;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int RA_W   = 10;
    localparam int RA_HI_W = RA_W - BYTE_W;

    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_PTR  = 2'd1;
    localparam logic [1:0] OFS_CHIP = 2'd2;
    localparam logic [1:0] OFS_MASK = 2'd3;

    localparam int PTR_STEP_BIT = 7;
    localparam int PTR_WO_BIT   = 5;
    localparam int PTR_CH_BIT   = 3;

    localparam logic [BYTE_W-1:0] PTR_RST     = 8'h50;
    localparam logic [BYTE_W-1:0] GEN_WO_MASK = 8'h04;

    localparam logic [IDX_W-1:0] IX_CMDBASE = 3'd0;
    localparam logic [IDX_W-1:0] IX_GENCFG  = 3'd1;
    localparam logic [IDX_W-1:0] IX_RALO    = 3'd2;
    localparam logic [IDX_W-1:0] IX_RACFG   = 3'd3;
    localparam logic [IDX_W-1:0] IX_CTLBASE = 3'd4;
    localparam logic [IDX_W-1:0] IX_DTIME   = 3'd5;
    localparam logic [IDX_W-1:0] IX_CTIME   = 3'd6;

    typedef struct packed {
        logic [WORD_W-1:0]  cmd_base;
        logic [WORD_W-1:0]  ctl_base;
        logic [BYTE_W-1:0]  gen;
        logic [BYTE_W-1:0]  ra_lo;
        logic [RA_HI_W-1:0] ra_hi;
        logic               ra_en;
        logic               mode4;
        logic [BYTE_W-1:0]  dtime;
        logic [BYTE_W-1:0]  ctime;
    } chan_regs_t;

    function automatic chan_regs_t chan_defaults(input logic secondary);
        chan_regs_t r;
        r.cmd_base = secondary ? 16'h0170 : 16'h01F0;
        r.ctl_base = secondary ? 16'h0376 : 16'h03F6;
        r.gen      = 8'h01;
        r.ra_lo    = '0;
        r.ra_hi    = '0;
        r.ra_en    = 1'b0;
        r.mode4    = 1'b0;
        r.dtime    = 8'hF5;
        r.ctime    = 8'hDE;
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] step_index(input logic [IDX_W-1:0] i);
        return (int'(i) >= NREG - 1) ? '0 : i + 1'b1;
    endfunction

endpackage

// File: rtl/cfgport_pointer.sv
module cfgport_pointer
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              step,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ptr_q,
    output logic              burst_off
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= PTR_RST;
            burst_off <= 1'b0;
        end else if (wr_en) begin
            ptr_q              <= wdata;
            ptr_q[PTR_WO_BIT]  <= 1'b0;
            burst_off          <= wdata[PTR_WO_BIT];
        end else if (step) begin
            ptr_q[IDX_W-1:0] <= step_index(ptr_q[IDX_W-1:0]);
        end
    end
endmodule

// File: rtl/cfgport_chan_bank.sv
module cfgport_chan_bank
    import cfgport_pkg::*;
#(
    parameter bit SECONDARY = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [1:0]         be,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata,
    output logic [RA_W-1:0]    ra_count,
    output logic               ra_enable,
    output logic               mode4,
    output logic               fifo_clr
);
    chan_regs_t r_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q      <= chan_defaults(SECONDARY);
            fifo_clr <= 1'b0;
        end else begin
            fifo_clr <= 1'b0;
            if (wr_en) begin
                case (idx)
                    IX_CMDBASE: begin
                        if (be[0]) r_q.cmd_base[BYTE_W-1:0]      <= wdata[BYTE_W-1:0];
                        if (be[1]) r_q.cmd_base[WORD_W-1:BYTE_W] <= wdata[WORD_W-1:BYTE_W];
                    end
                    IX_CTLBASE: begin
                        if (be[0]) r_q.ctl_base[BYTE_W-1:0]      <= wdata[BYTE_W-1:0];
                        if (be[1]) r_q.ctl_base[WORD_W-1:BYTE_W] <= wdata[WORD_W-1:BYTE_W];
                    end
                    IX_GENCFG: if (be[0]) r_q.gen   <= wdata[BYTE_W-1:0];
                    IX_RALO:   if (be[0]) r_q.ra_lo <= wdata[BYTE_W-1:0];
                    IX_RACFG:  if (be[0]) begin
                        r_q.ra_en <= wdata[7];
                        r_q.mode4 <= wdata[4];
                        r_q.ra_hi <= wdata[RA_HI_W-1:0];
                        fifo_clr  <= wdata[6];
                    end
                    IX_DTIME:  if (be[0]) r_q.dtime <= wdata[BYTE_W-1:0];
                    IX_CTIME:  if (be[0]) r_q.ctime <= wdata[BYTE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (idx)
            IX_CMDBASE: rdata = r_q.cmd_base;
            IX_CTLBASE: rdata = r_q.ctl_base;
            IX_GENCFG:  rdata = {{BYTE_W{1'b0}}, r_q.gen & ~GEN_WO_MASK};
            IX_DTIME:   rdata = {{BYTE_W{1'b0}}, r_q.dtime};
            IX_CTIME:   rdata = {{BYTE_W{1'b0}}, r_q.ctime};
            default:    rdata = '0;
        endcase
    end

    assign ra_count  = {r_q.ra_hi, r_q.ra_lo};
    assign ra_enable = r_q.ra_en;
    assign mode4     = r_q.mode4;
endmodule

// File: rtl/cfgport_irqctl.sv
module cfgport_irqctl
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_chip,
    input  logic              wr_mask,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NCH-1:0]    dev_stat,
    input  logic [NCH-1:0]    bm_stat,
    input  logic              strap,
    output logic [BYTE_W-1:0] chip_rd,
    output logic [BYTE_W-1:0] mask_rd,
    output logic [NCH-1:0]    irq_out,
    output logic              legacy_mode,
    output logic              test_mode
);
    logic [NCH-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q      <= '0;
            legacy_mode <= 1'b0;
            test_mode   <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= wdata[NCH-1:0];
            if (wr_chip) begin
                legacy_mode <= wdata[1];
                test_mode   <= wdata[0];
            end
        end
    end

    assign chip_rd = {6'b0, bm_stat[0], dev_stat[0]};
    assign mask_rd = {3'b0, strap, bm_stat[1], dev_stat[1], mask_q};
    assign irq_out = dev_stat & ~mask_q;
endmodule

// File: rtl/cfgport_regbank.sv
module cfgport_regbank
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_be,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic [1:0]        irq_dev_stat,
    input  logic [1:0]        irq_bm_stat,
    input  logic              legacy_strap,
    output logic [1:0]        irq_out,
    output logic              legacy_mode,
    output logic              test_mode,
    output logic              burst_off,
    output logic [1:0]        fifo_clr,
    output logic [1:0]        ra_enable,
    output logic [1:0]        mode4_tim,
    output logic [9:0]        ra_count_p,
    output logic [9:0]        ra_count_s
);
    logic [BYTE_W-1:0] ptr_q;
    logic [BYTE_W-1:0] chip_rd, mask_rd;
    logic [WORD_W-1:0] bank_rd [NCH];
    logic [RA_W-1:0]   bank_ra [NCH];

    logic data_wr, data_acc, step;
    assign data_wr  = host_wr && (host_addr == OFS_DATA);
    assign data_acc = (host_wr || host_rd) && (host_addr == OFS_DATA);
    assign step     = data_acc && ptr_q[PTR_STEP_BIT];

    cfgport_pointer u_ptr (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (host_wr && (host_addr == OFS_PTR) && host_be[0]),
        .step      (step),
        .wdata     (host_wdata[BYTE_W-1:0]),
        .ptr_q     (ptr_q),
        .burst_off (burst_off)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cfgport_chan_bank #(.SECONDARY(c == 1)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (data_wr && (int'(ptr_q[PTR_CH_BIT]) == c)),
            .idx       (ptr_q[IDX_W-1:0]),
            .be        (host_be),
            .wdata     (host_wdata),
            .rdata     (bank_rd[c]),
            .ra_count  (bank_ra[c]),
            .ra_enable (ra_enable[c]),
            .mode4     (mode4_tim[c]),
            .fifo_clr  (fifo_clr[c])
        );
    end

    cfgport_irqctl u_irq (
        .clk         (clk),
        .rst         (rst),
        .wr_chip     (host_wr && (host_addr == OFS_CHIP) && host_be[0]),
        .wr_mask     (host_wr && (host_addr == OFS_MASK) && host_be[0]),
        .wdata       (host_wdata[BYTE_W-1:0]),
        .dev_stat    (irq_dev_stat),
        .bm_stat     (irq_bm_stat),
        .strap       (legacy_strap),
        .chip_rd     (chip_rd),
        .mask_rd     (mask_rd),
        .irq_out     (irq_out),
        .legacy_mode (legacy_mode),
        .test_mode   (test_mode)
    );

    always_comb begin
        case (host_addr)
            OFS_DATA: host_rdata = bank_rd[ptr_q[PTR_CH_BIT]];
            OFS_PTR:  host_rdata = {{BYTE_W{1'b0}}, ptr_q};
            OFS_CHIP: host_rdata = {{BYTE_W{1'b0}}, chip_rd};
            default:  host_rdata = {{BYTE_W{1'b0}}, mask_rd};
        endcase
    end

    assign ra_count_p = bank_ra[0];
    assign ra_count_s = bank_ra[1];
endmodule

// File: rtl/cfgport_regbank_chk.sv
module cfgport_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  host_addr,
    input logic        host_wr,
    input logic        host_rd,
    input logic [1:0]  host_be,
    input logic [15:0] host_wdata,
    input logic [15:0] host_rdata,
    input logic [1:0]  irq_out,
    input logic [1:0]  fifo_clr,
    input logic [7:0]  ptr
);
    logic data_acc, ptr_wr;
    assign data_acc = (host_wr || host_rd) && host_addr == 2'd0;
    assign ptr_wr   = host_wr && host_addr == 2'd1 && host_be[0];

    assert_ptr_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ptr == 8'h50);

    assert_ptr_wo_R2: assert property (@(posedge clk) disable iff (rst)
        host_addr == 2'd1 |-> host_rdata[5] == 1'b0);

    assert_autoinc_R3: assert property (@(posedge clk) disable iff (rst)
        (data_acc && ptr[7]) |=>
            ptr[2:0] == (($past(ptr[2:0]) >= 3'd6) ? 3'd0 : $past(ptr[2:0]) + 3'd1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!ptr_wr && !(data_acc && ptr[7])) |=> $stable(ptr));

    assert_wo_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (host_addr == 2'd0 && (ptr[2:0] == 3'd2 || ptr[2:0] == 3'd3)) |-> host_rdata == 16'h0);

    assert_fifo_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_clr[0] |-> $past(host_wr && host_addr == 2'd0 && host_be[0] &&
                              host_wdata[6] && ptr[2:0] == 3'd3 && !ptr[3]));

    assert_idx7_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (host_addr == 2'd0 && ptr[2:0] == 3'd7) |-> host_rdata == 16'h0);

    assert_mask_irq_R11: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd3 && host_be[0] && host_wdata[0]) |=> !irq_out[0]);
endmodule

bind cfgport_regbank cfgport_regbank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_be    (host_be),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq_out    (irq_out),
    .fifo_clr   (fifo_clr),
    .ptr        (ptr_q)
);

// File: tb/cfgport_regbank_bench.sv
`timescale 1ns/1ps
module cfgport_regbank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_be = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [1:0]  irq_dev_stat = '0, irq_bm_stat = '0;
    logic        legacy_strap = 1'b0;
    logic [1:0]  irq_out, fifo_clr, ra_enable, mode4_tim;
    logic        legacy_mode, test_mode, burst_off;
    logic [9:0]  ra_count_p, ra_count_s;

    always #10 clk = ~clk;

    cfgport_regbank u_cfgport_regbank (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_dev_stat(irq_dev_stat), .irq_bm_stat(irq_bm_stat), .legacy_strap(legacy_strap),
        .irq_out(irq_out), .legacy_mode(legacy_mode), .test_mode(test_mode),
        .burst_off(burst_off), .fifo_clr(fifo_clr), .ra_enable(ra_enable),
        .mode4_tim(mode4_tim), .ra_count_p(ra_count_p), .ra_count_s(ra_count_s)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    int m_cmd[2], m_ctl[2], m_gen[2], m_ralo[2], m_rahi[2], m_dt[2], m_ct[2];
    int m_raen[2], m_m4[2], m_fifo[2];
    int m_ptr, m_burst, m_mask, m_leg, m_test;

    task automatic model_reset();
        m_cmd = '{32'h1F0, 32'h170};
        m_ctl = '{32'h3F6, 32'h376};
        for (int c = 0; c < 2; c++) begin
            m_gen[c] = 1; m_ralo[c] = 0; m_rahi[c] = 0; m_dt[c] = 'hF5; m_ct[c] = 'hDE;
            m_raen[c] = 0; m_m4[c] = 0; m_fifo[c] = 0;
        end
        m_ptr = 'h50; m_burst = 0; m_mask = 0; m_leg = 0; m_test = 0;
    endtask

    function automatic int exp_read(input int a);
        int ch = (m_ptr >> 3) & 1;
        int ix = m_ptr & 7;
        if (a == 1) return m_ptr;
        if (a == 2) return irq_bm_stat[0] * 2 + irq_dev_stat[0];
        if (a == 3) return legacy_strap * 16 + irq_bm_stat[1] * 8 + irq_dev_stat[1] * 4 + m_mask;
        case (ix)
            0: return m_cmd[ch];
            1: return m_gen[ch] & 'hFB;
            4: return m_ctl[ch];
            5: return m_dt[ch];
            6: return m_ct[ch];
            default: return 0;
        endcase
    endfunction

    task automatic model_apply(input int a, input bit w, input bit r, input int be, input int d);
        int ch = (m_ptr >> 3) & 1;
        int ix = m_ptr & 7;
        m_fifo[0] = 0; m_fifo[1] = 0;
        if (w && a == 0) begin
            case (ix)
                0: begin
                    if (be & 1) m_cmd[ch] = (m_cmd[ch] & 'hFF00) | (d & 'hFF);
                    if (be & 2) m_cmd[ch] = (m_cmd[ch] & 'hFF) | (d & 'hFF00);
                end
                4: begin
                    if (be & 1) m_ctl[ch] = (m_ctl[ch] & 'hFF00) | (d & 'hFF);
                    if (be & 2) m_ctl[ch] = (m_ctl[ch] & 'hFF) | (d & 'hFF00);
                end
                1: if (be & 1) m_gen[ch] = d & 'hFF;
                2: if (be & 1) m_ralo[ch] = d & 'hFF;
                3: if (be & 1) begin
                    m_raen[ch] = (d >> 7) & 1; m_m4[ch] = (d >> 4) & 1;
                    m_rahi[ch] = d & 3; m_fifo[ch] = (d >> 6) & 1;
                end
                5: if (be & 1) m_dt[ch] = d & 'hFF;
                6: if (be & 1) m_ct[ch] = d & 'hFF;
                default: ;
            endcase
        end
        if (w && (be & 1)) begin
            if (a == 1) begin m_ptr = d & 'hDF; m_burst = (d >> 5) & 1; end
            if (a == 2) begin m_leg = (d >> 1) & 1; m_test = d & 1; end
            if (a == 3) m_mask = d & 3;
        end
        if ((w || r) && a == 0 && (m_ptr & 'h80))
            m_ptr = (m_ptr & 'hF8) | ((ix >= 6) ? 0 : ix + 1);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic string read_tag(input int a);
        int ix = m_ptr & 7;
        if (a == 1) return "R2";
        if (a == 2) return "R9";
        if (a == 3) return "R10";
        if (ix == 7) return "R8";
        if (ix == 2 || ix == 3 || ix == 1) return "R6";
        return "R5";
    endfunction

    // one host cycle; outputs compared against the model every clock
    task automatic cyc(input int a, input bit w, input bit r, input int be, input int d,
                       input string tag = "");
        @(negedge clk);
        host_addr = a[1:0]; host_wr = w; host_rd = r; host_be = be[1:0]; host_wdata = d[15:0];
        #5;
        check((tag != "") ? tag : read_tag(a), int'(host_rdata), exp_read(a));
        check("R11", int'(irq_out), int'(irq_dev_stat & ~m_mask[1:0]));
        check("R7", int'(fifo_clr), m_fifo[1] * 2 + m_fifo[0]);
        check("R6", int'(ra_count_p), m_rahi[0] * 256 + m_ralo[0]);
        check("R6", int'(ra_count_s), m_rahi[1] * 256 + m_ralo[1]);
        check("R6", int'(ra_enable), m_raen[1] * 2 + m_raen[0]);
        check("R6", int'(mode4_tim), m_m4[1] * 2 + m_m4[0]);
        check("R9", int'({legacy_mode, test_mode}), m_leg * 2 + m_test);
        check("R2", int'(burst_off), m_burst);
        @(posedge clk);
        #1;
        model_apply(a, w, r, be, d);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset values
        cyc(1, 0, 1, 1, 0, "R1");
        cyc(3, 0, 1, 1, 0, "R1");
        for (int ch = 0; ch < 2; ch++) begin
            cyc(1, 1, 0, 1, 'h80 | (ch << 3), "R2");
            for (int k = 0; k < 8; k++) cyc(0, 0, 1, 3, 0, "R1");   // wraps 6 -> 0 (R3)
            cyc(1, 0, 1, 1, 0, "R3");
        end
        // R7 / R6 / R4: index 3 of secondary without auto-advance
        cyc(1, 1, 0, 1, 'h5B, "R2");
        cyc(0, 1, 0, 1, 'h00D3, "R7");
        cyc(0, 0, 1, 1, 0, "R6");
        cyc(1, 0, 1, 1, 0, "R4");
        cyc(1, 1, 0, 1, 'h5A, "R2");
        cyc(0, 1, 0, 1, 'h00A5, "R6");
        cyc(0, 0, 0, 0, 0, "R6");
        // R5: byte and word writes to a 16-bit register
        cyc(1, 1, 0, 1, 'h58, "R2");
        cyc(0, 1, 0, 1, 'hABCD, "R5");
        cyc(0, 0, 1, 3, 0, "R5");
        cyc(0, 1, 0, 3, 'h1234, "R5");
        cyc(0, 0, 1, 3, 0, "R5");
        // R8: index 7
        cyc(1, 1, 0, 1, 'h5F, "R2");
        cyc(0, 1, 0, 3, 'hFFFF, "R8");
        cyc(0, 0, 1, 3, 0, "R8");
        cyc(1, 1, 0, 1, 'hFF, "R2");                 // bit5 set, reads as 0
        cyc(0, 0, 1, 3, 0, "R8");
        cyc(1, 0, 1, 1, 0, "R3");                    // 7 advanced to 0
        // R6: write-only bit in general config
        cyc(1, 1, 0, 1, 'h51, "R2");
        cyc(0, 1, 0, 1, 'hFF, "R6");
        cyc(0, 0, 1, 1, 0, "R6");
        // R9 / R10 / R11
        irq_dev_stat = 2'b11; irq_bm_stat = 2'b01; legacy_strap = 1'b1;
        cyc(2, 1, 0, 1, 'h83, "R9");
        cyc(2, 0, 1, 1, 0, "R9");
        cyc(3, 1, 0, 1, 'h1D, "R10");
        cyc(3, 0, 1, 1, 0, "R10");
        irq_bm_stat = 2'b10; irq_dev_stat = 2'b10;
        cyc(3, 1, 0, 1, 'h02, "R11");
        cyc(3, 0, 1, 1, 0, "R10");
        cyc(2, 0, 1, 1, 0, "R9");
        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 2);
            irq_dev_stat = 2'($urandom); irq_bm_stat = 2'($urandom); legacy_strap = 1'($urandom);
            cyc($urandom_range(0, 3), op == 1, op == 2, $urandom_range(0, 3), $urandom);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule